// File: doc/BRIEF.md
# Multi-channel power-good monitor

This block merges the digital outputs of several per-channel voltage comparators into one active-high power-good indication. Each channel supplies an enable bit and two flags: one raised while its output sits above the upper trip point, which is set near 92% of the programmed level, and one raised while it sits below the lower trip point, which is set near 88%. Each channel keeps its own good/bad state with hysteresis between the two trip points. The block ignores a short dip under the lower trip point until that dip has lasted a programmable number of clock cycles. The window is sized to about 2 µs of system clock.

The combined flag is high only when at least one channel is enabled and every enabled channel is good. A disabled channel counts as good. The block also drives the pull-down enable of an open-drain output stage. A separate input forces that driver off, which models the output being pulled above the supply. The logical power-good value is not changed by that input.

Top module: `pg_monitor`

## Requirements
- R1: While reset is held, and after reset is released with no channel enabled, `pwr_good` is 0 and `pull_low` is 1 when `drv_disable` is 0.
- R2: An enabled channel in the bad state turns good at the clock edge where its `ch_above_hi` bit is 1 and its `ch_below_lo` bit is 0.
- R3: `pwr_good` is registered. It rises one clock edge after the edge on which the last enabled channel became good.
- R4: When an enabled channel turns bad, `pwr_good` falls one clock edge later.
- R5: An enabled channel with both flags at 0 keeps its state: a good channel stays good and a bad channel stays bad.
- R6: A good enabled channel turns bad only on the BLANK_CYC-th consecutive clock edge with `ch_below_lo` at 1. Any dip of BLANK_CYC-1 cycles or fewer leaves it good.
- R7: The count of consecutive low cycles restarts from zero after any single cycle in which `ch_below_lo` is 0.
- R8: A disabled channel counts as good in the combination. Disabling a channel clears it to the bad state, so after it is enabled again it must rise above the upper trip point before it is good.
- R9: With no channel enabled, `pwr_good` is 0 at the next edge.
- R10: `pull_low` is 1 exactly when `pwr_good` is 0 and `drv_disable` is 0. `drv_disable` has no effect on `pwr_good`.
- R11: While `ch_below_lo` is 1, a bad channel stays bad even when `ch_above_hi` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ch_en | input | NCH | Per-channel enable |
| ch_above_hi | input | NCH | Per-channel flag: output above the upper trip point |
| ch_below_lo | input | NCH | Per-channel flag: output below the lower trip point |
| drv_disable | input | 1 | Forces the open-drain pull-down off |
| pwr_good | output | 1 | Combined power-good, active high |
| pull_low | output | 1 | Enable for the open-drain pull-down transistor |

## Verification
The bench targets the blanking boundary. It holds the low flag for exactly BLANK_CYC-1 cycles and then for exactly BLANK_CYC cycles. An off-by-one counter would either drop power-good on a dip that should be tolerated or hold it through a real fault. It also splits two near-full dips with one clean cycle. A counter that does not restart would trip there. The remaining cases are these: a channel that is enabled but still low, a disabled channel, the all-disabled case, and conflicting flags while bad. A design that handled enables or priority wrongly would report good too early or stay stuck low. A random phase is then compared with the behavioural model on every clock, and it catches any latency slip on `pwr_good`.

// File: rtl/pg_mon_pkg.sv
package pg_mon_pkg;
  typedef enum logic {
    CH_BAD  = 1'b0,
    CH_GOOD = 1'b1
  } ch_state_e;
endpackage

// File: rtl/pg_chan.sv
module pg_chan
  import pg_mon_pkg::*;
#(
  parameter int BLANK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic above_hi,
  input  logic below_lo,
  output logic good
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

  ch_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en) begin
      state_d = CH_BAD;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        CH_BAD: begin
          cnt_d = '0;
          if (above_hi && !below_lo) state_d = CH_GOOD;
        end
        CH_GOOD: begin
          if (!below_lo) begin
            cnt_d = '0;
          end else if (cnt_q == LAST) begin
            state_d = CH_BAD;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = CH_BAD;
      endcase
    end
  end

  assign upd = (state_d != state_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_BAD;
      cnt_q   <= '0;
    end else if (upd) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign good = (state_q == CH_GOOD);

  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !good && above_hi && !below_lo) |=> good);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !above_hi && !below_lo) |=> $stable(good));
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !good);
  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && good && below_lo && cnt_q < LAST) |=> good);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(BLANK_CYC));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !below_lo |=> cnt_q == '0);
  p_conflict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!good && below_lo) |=> !good);
endmodule

// File: rtl/pg_combine.sv
module pg_combine #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] good,
  output logic           pwr_good
);
  logic pg_q, pg_d;
  logic any_en, all_ok;

  always_comb begin
    any_en = |en;
    all_ok = &(good | ~en);
    pg_d   = any_en && all_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pg_d;
  end

  assign pwr_good = pg_q;

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((en & ~good) != '0) |=> !pwr_good);
  p_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !pwr_good);
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((en != '0) && ((good | ~en) == '1)) |=> pwr_good);
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter int NCH       = 3,
  parameter int BLANK_CYC = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_above_hi,
  input  logic [NCH-1:0] ch_below_lo,
  input  logic           drv_disable,
  output logic           pwr_good,
  output logic           pull_low
);
  logic           rst_meta, rst_sync;
  logic [NCH-1:0] good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pg_chan #(.BLANK_CYC(BLANK_CYC)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync),
      .en       (ch_en[g]),
      .above_hi (ch_above_hi[g]),
      .below_lo (ch_below_lo[g]),
      .good     (good[g])
    );
  end

  pg_combine #(.NCH(NCH)) u_comb (
    .clk      (clk),
    .rst_n    (rst_sync),
    .en       (ch_en),
    .good     (good),
    .pwr_good (pwr_good)
  );

  assign pull_low = !pwr_good && !drv_disable;

  p_drv_off_r10: assert property (@(posedge clk) disable iff (!rst_sync)
    drv_disable |-> !pull_low);
  p_reset_r1: assert property (@(posedge clk)
    !rst_sync |-> !pwr_good);
endmodule

// File: tb/sim_pg_monitor.sv
module sim_pg_monitor;
  localparam int NCH = 3;
  localparam int BLK = 6;
  localparam int TCLK = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] ch_en, ch_above_hi, ch_below_lo;
  logic           drv_disable;
  logic           pwr_good, pull_low;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit m_good [NCH];
  int m_cnt  [NCH];
  bit m_pg;

  always #(TCLK/2) clk = ~clk;

  pg_monitor #(.NCH(NCH), .BLANK_CYC(BLK)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_above_hi(ch_above_hi),
    .ch_below_lo(ch_below_lo), .drv_disable(drv_disable),
    .pwr_good(pwr_good), .pull_low(pull_low)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit any_en = 0;
    bit all_ok = 1;
    for (int i = 0; i < NCH; i++) begin
      if (ch_en[i]) begin
        any_en = 1;
        if (!m_good[i]) all_ok = 0;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (!ch_en[i]) begin
        m_good[i] = 0; m_cnt[i] = 0;
      end else if (!m_good[i]) begin
        m_cnt[i] = 0;
        if (ch_above_hi[i] && !ch_below_lo[i]) m_good[i] = 1;
      end else if (!ch_below_lo[i]) begin
        m_cnt[i] = 0;
      end else begin
        m_cnt[i]++;
        if (m_cnt[i] >= BLK) begin m_good[i] = 0; m_cnt[i] = 0; end
      end
    end
    m_pg = any_en && all_ok;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " pwr_good vs model"}, pwr_good, m_pg);
    chk({"R10 pull_low vs model"}, pull_low, !m_pg && !drv_disable);
  endtask

  task automatic steps(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ch_en = '0; ch_above_hi = '0; ch_below_lo = '0; drv_disable = 1'b0;
    for (int i = 0; i < NCH; i++) begin m_good[i] = 0; m_cnt[i] = 0; end
    m_pg = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pwr_good", pwr_good, 1'b0);
    chk("R1 reset pull_low", pull_low, 1'b1);
    rst_n = 1'b1;
    steps(4, "R1");
    chk("R1 idle pwr_good", pwr_good, 1'b0);

    // R2/R3: channels 0,1 rise, channel 2 disabled (R8)
    ch_en = 3'b011; ch_above_hi = 3'b011;
    step("R2");
    chk("R3 latency pwr_good", pwr_good, 1'b0);
    step("R3");
    chk("R3 pwr_good up", pwr_good, 1'b1);
    chk("R8 disabled ch counts good", pwr_good, 1'b1);

    // R5: between thresholds
    ch_above_hi = '0;
    steps(5, "R5");
    chk("R5 hold good", pwr_good, 1'b1);

    // R6: dip of BLK-1 tolerated
    ch_below_lo = 3'b001;
    steps(BLK - 1, "R6");
    ch_below_lo = '0;
    steps(2, "R6");
    chk("R6 short dip blanked", pwr_good, 1'b1);

    // R7: two near-full dips split by one clean cycle
    ch_below_lo = 3'b010;
    steps(BLK - 1, "R7");
    ch_below_lo = '0;
    step("R7");
    ch_below_lo = 3'b010;
    steps(BLK - 1, "R7");
    ch_below_lo = '0;
    steps(2, "R7");
    chk("R7 counter restart", pwr_good, 1'b1);

    // R6/R4: full dip
    ch_below_lo = 3'b001;
    steps(BLK, "R6");
    chk("R6 still up at trip edge", pwr_good, 1'b1);
    step("R4");
    chk("R4 pwr_good drops", pwr_good, 1'b0);

    // R5 low side, R11 conflict
    ch_below_lo = '0;
    steps(4, "R5");
    chk("R5 hold bad", pwr_good, 1'b0);
    ch_above_hi = 3'b001; ch_below_lo = 3'b001;
    steps(3, "R11");
    chk("R11 conflict stays bad", pwr_good, 1'b0);
    ch_below_lo = '0;
    steps(2, "R2");
    chk("R2 recovery", pwr_good, 1'b1);

    // R8: enabling ch2 low drops pwr_good
    ch_above_hi = '0; ch_en = 3'b111;
    step("R8");
    chk("R8 new channel bad", pwr_good, 1'b0);
    ch_above_hi = 3'b100;
    steps(2, "R8");
    chk("R8 ch2 risen", pwr_good, 1'b1);
    ch_above_hi = '0; ch_en = 3'b011;
    steps(2, "R8");
    ch_en = 3'b111;
    step("R8");
    chk("R8 re-enable needs rise", pwr_good, 1'b0);
    ch_above_hi = 3'b100;
    steps(2, "R8");

    // R10
    drv_disable = 1'b1;
    #1;
    chk("R10 pull_low off when good", pull_low, 1'b0);
    steps(2, "R10");
    chk("R10 pwr_good unaffected", pwr_good, 1'b1);

    // R9
    ch_en = '0;
    step("R9");
    chk("R9 none enabled", pwr_good, 1'b0);
    chk("R10 pull_low off when not good", pull_low, 1'b0);
    drv_disable = 1'b0;
    #1;
    chk("R10 pull_low on", pull_low, 1'b1);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      ch_en = ($urandom_range(0, 9) == 0) ? 3'($urandom) : ch_en | 3'b001;
      for (int i = 0; i < NCH; i++) begin
        ch_above_hi[i] = ($urandom_range(0, 3) == 0);
        ch_below_lo[i] = ($urandom_range(0, 5) < 2);
      end
      drv_disable = ($urandom_range(0, 7) == 0);
      step("R6 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule